// File: doc/BRIEF.md
# GPIO Bank Controller with Edge Interrupts

This block is one bank of general-purpose I/O pins, 32 by default, attached to a simple word-wide register bus. Software uses it to choose whether each pin is an input or an output and to drive output levels. An output can be changed on its own, without a read-modify-write: one write-only register sets the chosen bits of the output latch and another clears them. Software can also read the pin levels, which are sampled through a two-flop synchroniser.

Each pin has separate enables for rising-edge and falling-edge detection. An enabled edge sets a sticky bit in the interrupt status register. That bit stays set until software writes a one to it. If an edge arrives in the same cycle as the clearing write, the edge takes priority. A per-pin enable mask gates the status bits onto a single level interrupt line.

The bank decodes a 1 KiB byte-addressed window. Reads are combinational from the address. Unmapped, misaligned and write-only offsets read as zero.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset the direction register reads all ones, so every pin is an input. The output latch, interrupt status, interrupt enable and both edge-enable registers read zero, and `irq` is low.
- R2: Offset 0x00 reads a constant identification word. Its value is 0x00000025: major 2 in bits [7:4] and minor 5 in bits [3:0]. Every offset that is not mapped, including the two write-only ports at 0x90 and 0x94, reads zero.
- R3: The direction register is at offset 0x34 and can be read and written. A bit value of 1 makes that pin an input and 0 makes it an output. The register drives `pin_dir` directly.
- R4: The output latch is at offset 0x3C, can be read and written, and drives `pin_out`. Writing to 0x94 sets every latch bit written as 1. Writing to 0x90 clears every latch bit written as 1. Bits written as 0 are left unchanged by both.
- R5: Offset 0x38 reads the synchronised pin levels. A pin change becomes visible after exactly two rising clock edges. Writes to 0x38 are ignored.
- R6: When a pin's bit in the rising-detect register (0x48) is 1, a low-to-high transition of the synchronised pin sets that pin's status bit at offset 0x18. The status bit is set three rising edges after the pin changes.
- R7: When a pin's bit in the falling-detect register (0x4C) is 1, a high-to-low transition of the synchronised pin sets that pin's status bit.
- R8: Status bits are sticky. Writing 1 to a bit at 0x18 clears it. Bits written as 0 keep their value.
- R9: If a detected edge and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R10: `irq` is high exactly when some pin has both its status bit and its enable bit at 0x1C set. Status bits still record events while their enable bit is 0.
- R11: A transition whose direction is not enabled for that pin leaves the pin's status bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (10) | Byte address within the register window |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | PINS (32) | Write data |
| bus_rdata | output | PINS (32) | Read data for bus_addr (combinational) |
| pin_in | input | PINS (32) | Asynchronous pin levels |
| pin_out | output | PINS (32) | Output latch |
| pin_dir | output | PINS (32) | Direction, 1 = input |
| irq | output | 1 | Level interrupt |

## Verification
Edge detection is exercised with single-pin rising and falling transitions. Each pin under test has only one direction enabled, which separates a detector wired to the wrong polarity from a correct one. The set and clear ports are driven with masks that overlap bits already set, which exposes a port that writes the whole latch instead of only the bits written as 1. The status clear is timed to land on the same edge as a new event, which shows whether events take priority. Staged pin changes sampled one edge early and on time pin down the synchroniser depth.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int PINS = 32,
  parameter int ADDR_W = 10,
  parameter logic [7:0] REV_ID = 8'h25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_dir,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_REV  = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h018);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'('h01C);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'('h034);
  localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'('h038);
  localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'('h03C);
  localparam logic [ADDR_W-1:0] A_RISE = ADDR_W'('h048);
  localparam logic [ADDR_W-1:0] A_FALL = ADDR_W'('h04C);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'('h090);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'('h094);
  localparam logic [PINS-1:0]   REV_WORD = {{(PINS-8){1'b0}}, REV_ID};

  logic [PINS-1:0] sync_a, sync_b, sync_prev;
  logic [PINS-1:0] status, ien, rise_en, fall_en;
  logic [PINS-1:0] hit, stat_clr;

  wire wr_stat = bus_we && (bus_addr == A_STAT);
  wire wr_set  = bus_we && (bus_addr == A_SET);
  wire wr_clr  = bus_we && (bus_addr == A_CLR);
  wire wr_dout = bus_we && (bus_addr == A_DOUT);

  assign hit = (sync_b & ~sync_prev & rise_en) | (~sync_b & sync_prev & fall_en);
  assign stat_clr = wr_stat ? bus_wdata : '0;
  assign irq = |(status & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a    <= '0;
      sync_b    <= '0;
      sync_prev <= '0;
    end else begin
      sync_a    <= pin_in;
      sync_b    <= sync_a;
      sync_prev <= sync_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien     <= '0;
      rise_en <= '0;
      fall_en <= '0;
      pin_dir <= '1;
    end else if (bus_we) begin
      case (bus_addr)
        A_IEN:   ien     <= bus_wdata;
        A_RISE:  rise_en <= bus_wdata;
        A_FALL:  fall_en <= bus_wdata;
        A_DIR:   pin_dir <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pin_out <= '0;
    else if (wr_dout) pin_out <= bus_wdata;
    else if (wr_set)  pin_out <= pin_out | bus_wdata;
    else if (wr_clr)  pin_out <= pin_out & ~bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~stat_clr) | hit;
  end

  always_comb begin
    case (bus_addr)
      A_REV:   bus_rdata = REV_WORD;
      A_STAT:  bus_rdata = status;
      A_IEN:   bus_rdata = ien;
      A_DIR:   bus_rdata = pin_dir;
      A_DIN:   bus_rdata = sync_b;
      A_DOUT:  bus_rdata = pin_out;
      A_RISE:  bus_rdata = rise_en;
      A_FALL:  bus_rdata = fall_en;
      default: bus_rdata = '0;
    endcase
  end

  // R4
  set_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

  // R4
  clr_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((pin_out & $past(bus_wdata)) == '0));

  // R8
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((status & $past(status)) == $past(status)));

  // R9
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((status & $past(hit)) == $past(hit)));

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);

  // R5
  din_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_DIN) |=> (sync_prev == $past(sync_b)));
endmodule

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [9:0]  bus_addr = '0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_dir;
  logic        irq;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  gpio_bank_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_dir(pin_dir), .irq(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic rdchk(string req, logic [9:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    rdchk("R1 dir", 10'h034, 32'hFFFF_FFFF);
    rdchk("R1 dout", 10'h03C, 32'h0);
    rdchk("R1 status", 10'h018, 32'h0);
    rdchk("R1 ien", 10'h01C, 32'h0);
    rdchk("R1 rise", 10'h048, 32'h0);
    rdchk("R1 fall", 10'h04C, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_map;
    rdchk("R2 rev", 10'h000, 32'h0000_0025);
    rdchk("R2 unmapped 0x04", 10'h004, 32'h0);
    rdchk("R2 unmapped 0x3FC", 10'h3FC, 32'h0);
    rdchk("R2 misaligned", 10'h035, 32'h0);
    wr(10'h094, 32'h1234_0000);
    rdchk("R2 set port reads 0", 10'h094, 32'h0);
    rdchk("R2 clr port reads 0", 10'h090, 32'h0);
    wr(10'h090, 32'hFFFF_FFFF);
  endtask

  task automatic t_dir;
    wr(10'h034, 32'hFFFF_0000);
    rdchk("R3 dir readback", 10'h034, 32'hFFFF_0000);
    check("R3 pin_dir", pin_dir, 32'hFFFF_0000);
  endtask

  task automatic t_out;
    wr(10'h03C, 32'h0);
    wr(10'h094, 32'h0000_00F0);
    rdchk("R4 set F0", 10'h03C, 32'h0000_00F0);
    wr(10'h094, 32'h0000_003F);
    rdchk("R4 set overlap", 10'h03C, 32'h0000_00FF);
    wr(10'h090, 32'h0000_003C);
    rdchk("R4 clr", 10'h03C, 32'h0000_00C3);
    check("R4 pin_out", pin_out, 32'h0000_00C3);
    wr(10'h03C, 32'hA000_0001);
    check("R4 direct write", pin_out, 32'hA000_0001);
  endtask

  task automatic t_in;
    pin_in = 32'hA5A5_5A5A;
    @(negedge clk);
    rdchk("R5 one edge old", 10'h038, 32'h0);
    @(negedge clk);
    rdchk("R5 two edges new", 10'h038, 32'hA5A5_5A5A);
    wr(10'h038, 32'h0);
    rdchk("R5 write ignored", 10'h038, 32'hA5A5_5A5A);
    pin_in = 32'h0;
    repeat (4) @(negedge clk);
    wr(10'h018, 32'hFFFF_FFFF);
  endtask

  task automatic t_rise_fall;
    wr(10'h048, 32'h0000_0001);
    wr(10'h04C, 32'h0000_0002);
    pin_in = 32'h0000_0002;
    repeat (4) @(negedge clk);
    rdchk("R11 rise on fall-only pin", 10'h018, 32'h0);
    pin_in = 32'h0000_0001;
    repeat (2) @(negedge clk);
    rdchk("R6 not before third edge", 10'h018, 32'h0);
    @(negedge clk);
    rdchk("R6 rise + R7 fall", 10'h018, 32'h0000_0003);
    pin_in = 32'h0;
    repeat (4) @(negedge clk);
    rdchk("R11 fall on rise-only pin stays", 10'h018, 32'h0000_0003);
    check("R10 masked irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_sticky;
    wr(10'h018, 32'h0);
    rdchk("R8 zero write keeps", 10'h018, 32'h0000_0003);
    wr(10'h018, 32'h0000_0002);
    rdchk("R8 clear one bit", 10'h018, 32'h0000_0001);
  endtask

  task automatic t_irq;
    wr(10'h01C, 32'h0000_0002);
    check("R10 other pin enabled", {31'b0, irq}, 32'h0);
    wr(10'h01C, 32'h0000_0001);
    check("R10 irq high", {31'b0, irq}, 32'h1);
    wr(10'h018, 32'h0000_0001);
    check("R10 irq low after clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_collide;
    pin_in = 32'h0000_0001;
    repeat (4) @(negedge clk);
    rdchk("R9 setup", 10'h018, 32'h0000_0001);
    pin_in = 32'h0;
    repeat (4) @(negedge clk);
    pin_in = 32'h0000_0001;
    repeat (2) @(negedge clk);
    wr(10'h018, 32'h0000_0001);
    rdchk("R9 event beats clear", 10'h018, 32'h0000_0001);
    wr(10'h018, 32'h0000_0001);
    rdchk("R8 later clear", 10'h018, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_map;
    t_dir;
    t_out;
    t_in;
    t_rise_fall;
    t_sticky;
    t_irq;
    t_collide;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule